// File: doc/BRIEF.md
# Coherent-Attribute Table Read Responder

This block serves table-read requests that a host places in a data-object-exchange mailbox of a switch upstream port. Software writes the request dwords one by one, then pulses `go`. The block checks the request and looks up the table entry the request names. It then fills a read mailbox with a response object: a three-dword response header followed by that entry's dwords. Software drains the read mailbox one dword per pop.

The table is derived from a present-port mask. When at least one downstream port is present, it holds two structures:
- Entry 0 describes access latency, with a base unit of 10000 and a value of 15 in each record.
- Entry 1 describes access bandwidth, with a base unit of 1000 and a value of 16 in each record.

Each structure carries one two-dword record per present downstream port, in ascending port order. Each record pairs the upstream-port ID with the downstream port's number, which is its bit index in the mask. The response header names the next entry handle, so software can walk the table. The walk ends on the all-ones handle.

A request that is too short, or that names an entry the table does not have, is dropped without producing any response.

Top module: `cdat_doe_responder`

## Requirements
- R1: After reset, `busy` is 0 and `rd_count` is 0.
- R2: A request is the first three dwords written with `wr_valid` since the previous accepted `go`. Any further dwords are ignored. If fewer than three dwords were written, the request is discarded.
- R3: If the length field of the request (dword 1, bits 17:0) is below 3, the request is discarded. The upper bits of dword 1 are ignored.
- R4: The entry handle is taken from dword 2, bits 31:16. A request is discarded when the handle is at or above the table size, which is 2 when any port is present and 0 when none is present. A discard keeps `busy` high for exactly one cycle and leaves `rd_count` at 0.
- R5: `busy` rises in the cycle after an accepted `go` and stays high for 1+L cycles, where L = 7 + 2·N and N is the number of present ports. A `go` that arrives while `busy` is high is ignored.
- R6: Response dword 0 holds the vendor ID 0x1E98 in bits 15:0, the object type 0x02 in bits 23:16, and zero in bits 31:24. Response dword 1 holds L in bits 17:0 and zero above.
- R7: Response dword 2 holds the response code 0x00 in bits 7:0 and the table type 0x00 in bits 15:8. Bits 31:16 hold the next handle: the requested handle plus 1, or 0xFFFF when the requested entry is the last one.
- R8: Response dwords 3 to 6 form the structure header:
  - Dword 3 holds the structure type 6 in bits 7:0 and the structure byte length 16+8·N in bits 31:16.
  - Dword 4 holds the data type: 0 for latency (entry 0) or 3 for bandwidth (entry 1).
  - Dword 5 holds the base unit: 10000 for latency or 1000 for bandwidth.
  - Dword 6 is zero.
- R9: Record k occupies response dwords 7+2k and 8+2k, and belongs to the k-th present port counted from bit 0.
  - The first dword holds the upstream-port ID 0x0100 in bits 15:0 and the port's bit index in bits 31:16.
  - The second dword holds 15 for latency or 16 for bandwidth in bits 15:0.
- R10: Once `busy` falls, `rd_count` equals L. Each `rd_pop` decrements `rd_count` and advances `rd_data` to the next dword. A pop while `busy` is high, or while `rd_count` is 0, has no effect.
- R11: The present-port mask is sampled at the accepted `go`. Changing the mask while the response is being built does not alter that response.
- R12: Every accepted `go` clears the previous read-mailbox contents, including when the new request is then discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_present | input | NPORT (8) | One bit per downstream port that is present and express-capable |
| wr_valid | input | 1 | Write one request dword |
| wr_data | input | 32 | Request dword |
| go | input | 1 | Start processing the written request |
| busy | output | 1 | High from the cycle after `go` until the response is complete |
| rd_count | output | PTR_W (5) | Response dwords left to read; 0 while busy |
| rd_data | output | 32 | Current read-mailbox dword |
| rd_pop | input | 1 | Consume the current dword |

## Verification
A stale word index or fill count inside the block shows up at the ports in one of two ways. The `busy` pulse has the wrong length, which is visible on the first request. Or `rd_count` disagrees with 7+2·N as soon as `busy` falls. A wrong rank-to-port selection puts the wrong port number into a record dword, so the sweep over every mask reports it on the first mask whose set bits are not contiguous from bit 0. Stale snapshot state or a failure to clear the mailbox is exposed by the disturbed and back-to-back requests: a record dword or `rd_count` then differs in the very next response.

// File: rtl/cdat_doe_pkg.sv
package cdat_doe_pkg;

    localparam logic [15:0] VENDOR_ID    = 16'h1E98;
    localparam logic [7:0]  OBJ_TYPE     = 8'h02;
    localparam logic [7:0]  RSP_CODE     = 8'h00;
    localparam logic [7:0]  TABLE_TYPE   = 8'h00;
    localparam logic [7:0]  STRUCT_TYPE  = 8'd6;
    localparam logic [7:0]  DT_LATENCY   = 8'd0;
    localparam logic [7:0]  DT_BANDWIDTH = 8'd3;
    localparam logic [15:0] USP_ID       = 16'h0100;
    localparam logic [31:0] LAT_UNIT     = 32'd10000;
    localparam logic [31:0] BW_UNIT      = 32'd1000;
    localparam logic [15:0] LAT_VALUE    = 16'd15;
    localparam logic [15:0] BW_VALUE     = 16'd16;
    localparam logic [15:0] END_HANDLE   = 16'hFFFF;

    localparam int REQ_DW        = 3;
    localparam int RSP_HDR_DW    = 3;
    localparam int STRUCT_HDR_DW = 4;
    localparam int REC_DW        = 2;
    localparam int NUM_ENTRIES   = 2;
    localparam int FIXED_DW      = RSP_HDR_DW + STRUCT_HDR_DW;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_BUILD = 2'd2
    } resp_state_e;

    typedef struct packed {
        logic [17:0] len_dw;
        logic [15:0] handle;
        logic [1:0]  words;
    } req_info_t;

    function automatic logic [15:0] next_handle(input logic [15:0] h);
        return (h == 16'(NUM_ENTRIES - 1)) ? END_HANDLE : h + 16'd1;
    endfunction

endpackage

// File: rtl/port_rank_sel.sv
module port_rank_sel #(
    parameter int NPORT = 8,
    parameter int CNT_W = $clog2(NPORT + 1),
    parameter int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0] mask,
    input  logic [CNT_W-1:0] rank,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        logic [CNT_W-1:0] seen;
        logic             found;
        seen  = '0;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (mask[i]) begin
                if (!found && seen == rank) begin
                    idx   = IDX_W'(i);
                    found = 1'b1;
                end
                seen = seen + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cdat_word_gen.sv
module cdat_word_gen
    import cdat_doe_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int PTR_W = 5
) (
    input  logic [NPORT-1:0] mask,
    input  logic [15:0]      handle,
    input  logic [PTR_W-1:0] widx,
    output logic [31:0]      word
);
    localparam int CNT_W = $clog2(NPORT + 1);
    localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic [CNT_W-1:0] npop;
    logic [PTR_W-1:0] len_dw;
    logic [15:0]      len_bytes;
    logic [PTR_W-1:0] rec_off;
    logic [CNT_W-1:0] rank;
    logic [IDX_W-1:0] port_idx;
    logic             is_bw;

    assign npop      = CNT_W'($countones(mask));
    assign len_dw    = PTR_W'(FIXED_DW) + PTR_W'({npop, 1'b0});
    assign len_bytes = 16'(STRUCT_HDR_DW * 4) + 16'({npop, 3'b000});
    assign rec_off   = widx - PTR_W'(FIXED_DW);
    assign rank      = CNT_W'(rec_off >> 1);
    assign is_bw     = handle[0];

    port_rank_sel #(.NPORT(NPORT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rank (
        .mask (mask),
        .rank (rank),
        .idx  (port_idx)
    );

    always_comb begin
        unique case (widx)
            PTR_W'(0): word = {8'h00, OBJ_TYPE, VENDOR_ID};
            PTR_W'(1): word = {14'h0, 18'(len_dw)};
            PTR_W'(2): word = {next_handle(handle), TABLE_TYPE, RSP_CODE};
            PTR_W'(3): word = {len_bytes, 8'h00, STRUCT_TYPE};
            PTR_W'(4): word = {24'h0, is_bw ? DT_BANDWIDTH : DT_LATENCY};
            PTR_W'(5): word = is_bw ? BW_UNIT : LAT_UNIT;
            PTR_W'(6): word = 32'h0;
            default: begin
                if (!rec_off[0]) word = {16'(port_idx), USP_ID};
                else             word = {16'h0, is_bw ? BW_VALUE : LAT_VALUE};
            end
        endcase
    end
endmodule

// File: rtl/rd_mbox.sv
module rd_mbox #(
    parameter int DEPTH = 23,
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [31:0]      rd_data
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = (rd_addr < PTR_W'(DEPTH)) ? mem[rd_addr] : 32'h0;

    a_r10_wr_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr < PTR_W'(DEPTH)));
endmodule

// File: rtl/cdat_doe_responder.sv
module cdat_doe_responder
    import cdat_doe_pkg::*;
#(
    parameter int NPORT    = 8,
    parameter int RD_DEPTH = FIXED_DW + REC_DW * NPORT,
    parameter int PTR_W    = $clog2(RD_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] port_present,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    input  logic             go,
    output logic             busy,
    output logic [PTR_W-1:0] rd_count,
    output logic [31:0]      rd_data,
    input  logic             rd_pop
);
    localparam int CNT_W = $clog2(NPORT + 1);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    resp_state_e      state_q;
    req_info_t        req_q;
    logic [NPORT-1:0] mask_q;
    logic [15:0]      handle_q;
    logic             accept_q;
    logic [PTR_W-1:0] len_q;
    logic [PTR_W-1:0] idx_q;
    logic [PTR_W-1:0] fill_q;
    logic [PTR_W-1:0] rptr_q;

    logic [CNT_W-1:0] npop_now;
    logic [PTR_W-1:0] len_now;
    logic [15:0]      entries_now;
    logic             start;
    logic             req_ok;
    logic [31:0]      gen_word;
    logic             wr_en;

    assign npop_now    = CNT_W'($countones(port_present));
    assign len_now     = PTR_W'(FIXED_DW) + PTR_W'({npop_now, 1'b0});
    assign entries_now = (npop_now == '0) ? 16'd0 : 16'(NUM_ENTRIES);
    assign start       = go && (state_q == ST_IDLE);
    assign req_ok      = (req_q.words == 2'(REQ_DW))
                      && (req_q.len_dw >= 18'(REQ_DW))
                      && (req_q.handle < entries_now);
    assign wr_en       = (state_q == ST_BUILD);
    assign busy        = (state_q != ST_IDLE);
    assign rd_count    = busy ? '0 : (fill_q - rptr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (start) begin
            req_q.words <= '0;
        end else if (wr_valid && req_q.words != 2'(REQ_DW)) begin
            if (req_q.words == 2'd1) req_q.len_dw <= wr_data[17:0];
            if (req_q.words == 2'd2) req_q.handle <= wr_data[31:16];
            req_q.words <= req_q.words + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mask_q   <= '0;
            handle_q <= '0;
            accept_q <= 1'b0;
            len_q    <= '0;
            idx_q    <= '0;
            fill_q   <= '0;
            rptr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mask_q   <= port_present;
                        handle_q <= req_q.handle;
                        accept_q <= req_ok;
                        len_q    <= len_now;
                        fill_q   <= '0;
                        rptr_q   <= '0;
                        state_q  <= ST_CHECK;
                    end else if (rd_pop && rptr_q != fill_q) begin
                        rptr_q <= rptr_q + ONE;
                    end
                end
                ST_CHECK: begin
                    idx_q   <= '0;
                    state_q <= accept_q ? ST_BUILD : ST_IDLE;
                end
                ST_BUILD: begin
                    idx_q  <= idx_q + ONE;
                    fill_q <= fill_q + ONE;
                    if (idx_q == len_q - ONE) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    cdat_word_gen #(.NPORT(NPORT), .PTR_W(PTR_W)) u_gen (
        .mask   (mask_q),
        .handle (handle_q),
        .widx   (idx_q),
        .word   (gen_word)
    );

    rd_mbox #(.DEPTH(RD_DEPTH), .PTR_W(PTR_W)) u_mbox (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (idx_q),
        .wr_data (gen_word),
        .rd_addr (rptr_q),
        .rd_data (rd_data)
    );

    a_r5_go_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> busy);

    a_r5_build_fill_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUILD) |=> (fill_q == $past(fill_q) + ONE));

    a_r4_discard_empty: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && !accept_q) |=> (!busy && rd_count == '0));

    a_r10_rptr_bound: assert property (@(posedge clk) disable iff (rst)
        rptr_q <= fill_q);

    a_r10_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_q <= PTR_W'(RD_DEPTH));

    a_r10_busy_blocks_pop: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rptr_q));
endmodule

// File: tb/cdat_doe_responder_test.sv
`timescale 1ns/1ps
module cdat_doe_responder_test;
    localparam int NPORT = 8;
    localparam int PTR_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NPORT-1:0] port_present = '0;
    logic             wr_valid = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             go = 1'b0;
    logic             busy;
    logic [PTR_W-1:0] rd_count;
    logic [31:0]      rd_data;
    logic             rd_pop = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cdat_doe_responder #(.NPORT(NPORT)) uut (
        .clk(clk), .rst(rst), .port_present(port_present),
        .wr_valid(wr_valid), .wr_data(wr_data), .go(go),
        .busy(busy), .rd_count(rd_count), .rd_data(rd_data), .rd_pop(rd_pop)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [7:0] m);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] m,
                                             input logic [15:0] h, input int i);
        int n = popc(m);
        bit bw = (h == 16'd1);
        if (i == 0) return 32'h0002_1E98;
        if (i == 1) return 32'(7 + 2 * n);
        if (i == 2) return {(h == 16'd1) ? 16'hFFFF : h + 16'd1, 16'h0000};
        if (i == 3) return {16'(16 + 8 * n), 16'h0006};
        if (i == 4) return bw ? 32'd3 : 32'd0;
        if (i == 5) return bw ? 32'd1000 : 32'd10000;
        if (i == 6) return 32'd0;
        begin
            int k = (i - 7) / 2;
            int seen = 0;
            int pid = 0;
            for (int b = 0; b < 8; b++) begin
                if (m[b]) begin
                    if (seen == k) pid = b;
                    seen++;
                end
            end
            if (((i - 7) % 2) == 0) return {16'(pid), 16'h0100};
            return bw ? 32'd16 : 32'd15;
        end
    endfunction

    task automatic write_req(input logic [31:0] w1, input logic [31:0] w2,
                             input int nw);
        for (int i = 0; i < nw; i++) begin
            wr_valid = 1'b1;
            wr_data  = (i == 0) ? 32'h0002_1E98 : (i == 1) ? w1 :
                       (i == 2) ? w2 : 32'hFFFF_0000;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wr_data  = '0;
    endtask

    task automatic fire(input bit disturb, input logic [7:0] m, output int cyc);
        go = 1'b1;
        @(negedge clk);
        go  = 1'b0;
        cyc = 0;
        while (busy && cyc < 100) begin
            cyc++;
            if (disturb && cyc == 3) begin
                go = 1'b1;
                rd_pop = 1'b1;
                port_present = ~m;
            end else begin
                go = 1'b0;
                rd_pop = 1'b0;
            end
            @(negedge clk);
        end
        go = 1'b0;
        rd_pop = 1'b0;
        port_present = m;
    endtask

    task automatic drain(input logic [7:0] m, input logic [15:0] h,
                         input string tag);
        int len = 7 + 2 * popc(m);
        chk(rd_count == PTR_W'(len), "R10 count after build",
            32'(rd_count), 32'(len));
        for (int i = 0; i < len; i++) begin
            logic [31:0] e = exp_word(m, h, i);
            chk(rd_data == e, tag, rd_data, e);
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
        chk(rd_count == '0, "R10 count drained", 32'(rd_count), 32'd0);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        chk(rd_count == '0, "R10 pop at empty ignored", 32'(rd_count), 32'd0);
    endtask

    task automatic expect_discard(input string tag);
        int cyc;
        fire(1'b0, port_present, cyc);
        chk(cyc == 1, tag, 32'(cyc), 32'd1);
        chk(rd_count == '0, tag, 32'(rd_count), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
        chk(rd_count == '0, "R1 rd_count after reset", 32'(rd_count), 32'd0);

        // R5 R6 R7 R8 R9 R4: sweep every mask and both handles
        for (int m = 0; m < 256; m++) begin
            for (int h = 0; h < 2; h++) begin
                port_present = 8'(m);
                write_req(32'd3, {16'(h), 16'h0000}, 3);
                fire(1'b0, 8'(m), cyc);
                if (m == 0) begin
                    chk(cyc == 1, "R4 empty table discard", 32'(cyc), 32'd1);
                    chk(rd_count == '0, "R4 empty table no data",
                        32'(rd_count), 32'd0);
                end else begin
                    chk(cyc == 8 + 2 * popc(8'(m)), "R5 busy length",
                        32'(cyc), 32'(8 + 2 * popc(8'(m))));
                    drain(8'(m), 16'(h), "R6 R7 R8 R9 response dword");
                end
            end
        end

        port_present = 8'hFF;
        write_req(32'd3, 32'h0002_0000, 3);
        expect_discard("R4 handle 2 discard");
        write_req(32'd3, 32'hFFFF_0000, 3);
        expect_discard("R4 handle FFFF discard");

        write_req(32'd2, 32'h0000_0000, 3);
        expect_discard("R3 length 2 discard");
        write_req(32'd0, 32'h0000_0000, 3);
        expect_discard("R3 length 0 discard");

        port_present = 8'hA5;
        write_req(32'hFFFC_0003, 32'h0001_0000, 3);
        fire(1'b0, 8'hA5, cyc);
        chk(cyc == 16, "R3 upper length bits ignored", 32'(cyc), 32'd16);
        drain(8'hA5, 16'd1, "R3 upper bits response");

        write_req(32'd3, 32'h0000_0000, 2);
        expect_discard("R2 two dwords discard");
        port_present = 8'h3C;
        write_req(32'd3, 32'h0000_0000, 4);
        fire(1'b0, 8'h3C, cyc);
        chk(cyc == 16, "R2 extra dword ignored busy", 32'(cyc), 32'd16);
        drain(8'h3C, 16'd0, "R2 extra dword ignored data");

        // R5 R10 R11: go, pop and mask change while busy
        port_present = 8'h96;
        write_req(32'd3, 32'h0001_0000, 3);
        fire(1'b1, 8'h96, cyc);
        chk(cyc == 16, "R5 go while busy ignored", 32'(cyc), 32'd16);
        drain(8'h96, 16'd1, "R11 snapshot mask response");

        // R12: undrained response cleared by a discarded request
        port_present = 8'h81;
        write_req(32'd3, 32'h0000_0000, 3);
        fire(1'b0, 8'h81, cyc);
        chk(rd_count == PTR_W'(11), "R12 response present", 32'(rd_count), 32'd11);
        write_req(32'd1, 32'h0000_0000, 3);
        expect_discard("R12 old contents cleared");

        // R12: undrained response replaced by a new one
        write_req(32'd3, 32'h0000_0000, 3);
        fire(1'b0, 8'h81, cyc);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        write_req(32'd3, 32'h0001_0000, 3);
        fire(1'b0, 8'h81, cyc);
        drain(8'h81, 16'd1, "R12 fresh response");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule